// File: doc/BRIEF.md
# NAND Command and Address Cycle Sequencer

This block turns a single register write into a complete command phase on an 8-bit NAND bus. Software first loads the address word (and, for five-byte addresses, a separate first-address-byte register), then writes a packed command word. The engine then selects one of eight chips and emits a first command byte with the command latch high, up to five address bytes with the address latch high, and an optional second command byte. Each byte is clocked by a write strobe whose low time comes from a programmable clock count.

A status register records sequence completion, a rising edge on the flash ready/busy line and a data-transfer-done pulse from an external data mover. Status reads clear the recorded bits. An interrupt mask, changed through separate set and clear registers, selects which status bits drive the interrupt line. A control register switches the engine on and off. When the engine is off, all chip enables stay high. When the command word requests a data phase, a one-clock hand-off pulse with the direction bit goes out at the end of the sequence.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset all chip enables, the write strobe and the interrupt are inactive. CLE, ALE and the bus are low. The status register (offset 1) and the mask (offset 4) read zero. The engine is off.
- R2: A write to the command register (offset 7) launches a sequence only when the engine is on and idle. Its fields are: first command in bits 9:2, second command in bits 17:10, second-command-valid in bit 18, address count in bits 21:19, chip ID in bits 24:22, data enable in bit 25 and write direction in bit 26.
- R3: The bytes go out in this order: the first command with CLE high, then the address bytes with ALE high, then the second command with CLE high only when bit 18 is set. CLE and ALE are never high together.
- R4: With an address count below five, the address bytes come from the address word (offset 6), least significant byte first. Counts of 6 and 7 behave as 5.
- R5: With an address count of five, the first address byte comes from bits 7:0 of the first-byte register (offset 5). Bytes 0 to 3 of the address word follow.
- R6: During a sequence only the chip enable indexed by the chip ID is low. All others stay high.
- R7: The write strobe stays low for exactly T clocks per byte, where T is bits 3:0 of the timing register (offset 8). A value of 0 acts as 1, and the reset value is 2. The active latch signal is high one clock before the strobe falls and one clock after it rises.
- R8: Bit 27 of the command register reads 1 while a sequence runs. A command write during that time is ignored and sets the sticky error bit 8 of the status register.
- R9: Status bit 17 is set when a sequence completes. A status read returns the recorded bits and clears them.
- R10: A rising edge on the ready/busy input sets status bit 24, and a falling edge does not. A pulse on the data-done input sets status bit 16.
- R11: A write of ones to offset 2 sets mask bits and a write of ones to offset 3 clears them. Mask bits sit at positions 16, 17 and 24 and read back at offset 4. The interrupt is the OR of the status bits ANDed with the mask.
- R12: In the control register (offset 0), bit 0 turns the engine on and bit 1 turns it off; off wins when both are set. Bit 0 reads back the state. While the engine is off, all chip enables stay high and command writes have no effect.
- R13: When a status event and a status read fall in the same clock, the read returns the earlier value and the new event stays recorded.
- R14: At the end of a sequence with data enable set, the hand-off request pulses for one clock and the direction output carries bit 26. With data enable clear, no pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, valid the clock after reg_rd |
| xfer_done_i | input | 1 | Data-transfer-done pulse from the data mover |
| nand_rb_i | input | 1 | Flash ready/busy line, high when ready |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_io | output | 8 | Bus byte |
| xfer_req_o | output | 1 | One-clock data-phase hand-off request |
| xfer_wr_o | output | 1 | Direction of the handed-off data phase |
| irq_o | output | 1 | Interrupt request |

## Verification
The clear performed by a status read and the setting of a status bit by a new event can happen in the same clock. The bench provokes this by raising the data-done pulse in the same cycle as the read strobe for the status register. It judges the result by two reads: the first must show bit 16 clear, because it returns the earlier value, and the second must show it set. A second overlap is a command write that lands while a sequence is still running. The scoreboard confirms that no extra bytes appear on the bus, and the status read confirms the error bit.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int REG_W    = 32;
  localparam int RA_W     = 4;
  localparam int BYTE_W   = 8;
  localparam int CSID_W   = 3;
  localparam int NADDR_W  = 3;
  localparam int MAX_ADDR = 5;
  localparam int AWORD_BYTES = REG_W / BYTE_W;

  // command word field positions
  localparam int CMD1_LSB  = 2;
  localparam int CMD2_LSB  = 10;
  localparam int VCMD2_BIT = 18;
  localparam int NADDR_LSB = 19;
  localparam int CSID_LSB  = 22;
  localparam int DEN_BIT   = 25;
  localparam int DWR_BIT   = 26;
  localparam int BUSY_BIT  = 27;

  // status / mask bit positions
  localparam int ST_ERR  = 8;
  localparam int ST_XFER = 16;
  localparam int ST_CMD  = 17;
  localparam int ST_RB   = 24;

  // register word offsets
  localparam logic [RA_W-1:0] RA_CTRL  = 4'd0;
  localparam logic [RA_W-1:0] RA_STAT  = 4'd1;
  localparam logic [RA_W-1:0] RA_IEN   = 4'd2;
  localparam logic [RA_W-1:0] RA_IDIS  = 4'd3;
  localparam logic [RA_W-1:0] RA_IMASK = 4'd4;
  localparam logic [RA_W-1:0] RA_CYC0  = 4'd5;
  localparam logic [RA_W-1:0] RA_ADDR  = 4'd6;
  localparam logic [RA_W-1:0] RA_CMD   = 4'd7;
  localparam logic [RA_W-1:0] RA_TIME  = 4'd8;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  typedef struct packed {
    logic [BYTE_W-1:0]  cmd1;
    logic [BYTE_W-1:0]  cmd2;
    logic               vcmd2;
    logic [NADDR_W-1:0] naddr;
    logic [CSID_W-1:0]  csid;
    logic               den;
    logic               dwr;
  } cmd_word_t;

  function automatic cmd_word_t unpack_cmd(input logic [REG_W-1:0] w);
    cmd_word_t c;
    c.cmd1  = w[CMD1_LSB +: BYTE_W];
    c.cmd2  = w[CMD2_LSB +: BYTE_W];
    c.vcmd2 = w[VCMD2_BIT];
    c.naddr = w[NADDR_LSB +: NADDR_W];
    c.csid  = w[CSID_LSB +: CSID_W];
    c.den   = w[DEN_BIT];
    c.dwr   = w[DWR_BIT];
    return c;
  endfunction
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs import nand_seq_pkg::*; #(
  parameter int CNT_W      = 4,
  parameter int DEF_STROBE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              seq_done,
  input  logic              rb_rise,
  input  logic              xfer_done,
  output logic              en,
  output logic              launch,
  output logic [REG_W-1:0]  cmd_word,
  output logic [REG_W-1:0]  addr_word,
  output logic [BYTE_W-1:0] cyc0,
  output logic [CNT_W-1:0]  strobe_t,
  output logic              err_flag,
  output logic [2:0]        imask,
  output logic              irq
);
  logic [2:0] sts_q;      // {rb, cmd, xfer}
  logic [2:0] ev, set_bits, clr_bits;
  logic       wr_cmd, stat_rd;
  logic [REG_W-1:0] rd_mux, stat_word, mask_word;

  assign wr_cmd   = reg_wr && (reg_addr == RA_CMD);
  assign stat_rd  = reg_rd && (reg_addr == RA_STAT);
  assign launch   = wr_cmd && en && !busy;
  assign cmd_word = reg_wdata;
  assign ev       = {rb_rise, seq_done, xfer_done};
  assign set_bits = (reg_wr && reg_addr == RA_IEN)
                    ? {reg_wdata[ST_RB], reg_wdata[ST_CMD], reg_wdata[ST_XFER]} : 3'b000;
  assign clr_bits = (reg_wr && reg_addr == RA_IDIS)
                    ? {reg_wdata[ST_RB], reg_wdata[ST_CMD], reg_wdata[ST_XFER]} : 3'b000;

  always_comb begin
    stat_word          = '0;
    stat_word[ST_ERR]  = err_flag;
    stat_word[ST_XFER] = sts_q[0];
    stat_word[ST_CMD]  = sts_q[1];
    stat_word[ST_RB]   = sts_q[2];
    mask_word          = '0;
    mask_word[ST_XFER] = imask[0];
    mask_word[ST_CMD]  = imask[1];
    mask_word[ST_RB]   = imask[2];
    rd_mux = '0;
    case (reg_addr)
      RA_CTRL:  rd_mux[0] = en;
      RA_STAT:  rd_mux = stat_word;
      RA_IMASK: rd_mux = mask_word;
      RA_CYC0:  rd_mux[BYTE_W-1:0] = cyc0;
      RA_ADDR:  rd_mux = addr_word;
      RA_CMD:   rd_mux[BUSY_BIT] = busy;
      RA_TIME:  rd_mux[CNT_W-1:0] = strobe_t;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      imask     <= '0;
      sts_q     <= '0;
      err_flag  <= 1'b0;
      cyc0      <= '0;
      addr_word <= '0;
      strobe_t  <= CNT_W'(DEF_STROBE);
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_CTRL) begin
        if (reg_wdata[1])      en <= 1'b0;
        else if (reg_wdata[0]) en <= 1'b1;
      end
      if (reg_wr && reg_addr == RA_CYC0) cyc0      <= reg_wdata[BYTE_W-1:0];
      if (reg_wr && reg_addr == RA_ADDR) addr_word <= reg_wdata;
      if (reg_wr && reg_addr == RA_TIME) strobe_t  <= reg_wdata[CNT_W-1:0];
      imask    <= (imask | set_bits) & ~clr_bits;
      // a new event in the same clock as a clearing read survives
      sts_q    <= (stat_rd ? 3'b000 : sts_q) | ev;
      err_flag <= (stat_rd ? 1'b0 : err_flag) | (wr_cmd && busy);
      if (reg_rd) reg_rdata <= rd_mux;
      irq <= |(sts_q & imask);
    end
  end
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine import nand_seq_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              launch,
  input  logic [REG_W-1:0]  cmd_word,
  input  logic [REG_W-1:0]  addr_word,
  input  logic [BYTE_W-1:0] cyc0,
  input  logic [CNT_W-1:0]  strobe_t,
  output logic              busy,
  output logic              done,
  output logic              strobe_low,
  output logic              slot_cle,
  output logic              slot_ale,
  output logic [BYTE_W-1:0] slot_byte,
  output logic [CSID_W-1:0] cs,
  output logic              xfer_req,
  output logic              xfer_wr
);
  localparam int IDX_W = NADDR_W;

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q, width_q;
  logic [IDX_W-1:0]   idx_q, last_q, na_q, na_in, j;
  logic [BYTE_W-1:0]  cmd1_q, cmd2_q, cyc0_q;
  logic [REG_W-1:0]   addr_q;
  logic               den_q, dwr_q;
  logic [1:0]         k;
  logic [BYTE_W-1:0]  abytes [AWORD_BYTES];
  cmd_word_t          cw;
  logic               unused_bits;

  assign cw          = unpack_cmd(cmd_word);
  assign unused_bits = ^{cmd_word[CMD1_LSB-1:0], cmd_word[REG_W-1:BUSY_BIT]};
  assign na_in       = (cw.naddr > IDX_W'(MAX_ADDR)) ? IDX_W'(MAX_ADDR) : cw.naddr;

  for (genvar b = 0; b < AWORD_BYTES; b++) begin : g_abyte
    assign abytes[b] = addr_q[b*BYTE_W +: BYTE_W];
  end

  assign busy       = (phase_q != PH_IDLE);
  assign strobe_low = (phase_q == PH_STROBE);
  assign done       = en && (phase_q == PH_HOLD) && (idx_q == last_q);

  always_comb begin
    slot_cle  = 1'b0;
    slot_ale  = 1'b0;
    slot_byte = cmd1_q;
    j         = idx_q - IDX_W'(1);
    k         = (na_q == IDX_W'(MAX_ADDR)) ? 2'(j - IDX_W'(1)) : 2'(j);
    if (idx_q == '0) begin
      slot_cle = 1'b1;
    end else if (idx_q <= na_q) begin
      slot_ale = 1'b1;
      if (na_q == IDX_W'(MAX_ADDR) && j == '0) slot_byte = cyc0_q;
      else                                      slot_byte = abytes[k];
    end else begin
      slot_cle  = 1'b1;
      slot_byte = cmd2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      width_q  <= CNT_W'(1);
      idx_q    <= '0;
      last_q   <= '0;
      na_q     <= '0;
      cmd1_q   <= '0;
      cmd2_q   <= '0;
      cyc0_q   <= '0;
      addr_q   <= '0;
      den_q    <= 1'b0;
      dwr_q    <= 1'b0;
      cs       <= '0;
      xfer_req <= 1'b0;
      xfer_wr  <= 1'b0;
    end else begin
      xfer_req <= done && den_q;
      if (done) xfer_wr <= dwr_q;
      if (!en) begin
        phase_q <= PH_IDLE;
      end else begin
        case (phase_q)
          PH_IDLE: if (launch) begin
            phase_q <= PH_SETUP;
            idx_q   <= '0;
            na_q    <= na_in;
            last_q  <= na_in + IDX_W'(cw.vcmd2);
            cmd1_q  <= cw.cmd1;
            cmd2_q  <= cw.cmd2;
            cyc0_q  <= cyc0;
            addr_q  <= addr_word;
            den_q   <= cw.den;
            dwr_q   <= cw.dwr;
            cs      <= cw.csid;
            width_q <= (strobe_t == '0) ? CNT_W'(1) : strobe_t;
          end
          PH_SETUP: begin
            phase_q <= PH_STROBE;
            cnt_q   <= CNT_W'(1);
          end
          PH_STROBE: begin
            if (cnt_q >= width_q) phase_q <= PH_HOLD;
            else                  cnt_q   <= cnt_q + CNT_W'(1);
          end
          PH_HOLD: begin
            if (idx_q == last_q) phase_q <= PH_IDLE;
            else begin
              idx_q   <= idx_q + IDX_W'(1);
              phase_q <= PH_SETUP;
            end
          end
          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nand_ce_decode.sv
module nand_ce_decode #(
  parameter int NUM_CS = 8,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic [CS_W-1:0]   sel,
  output logic [NUM_CS-1:0] ce_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) ce_n[i] <= 1'b1;
      else     ce_n[i] <= !(active && sel == CS_W'(i));
    end
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq import nand_seq_pkg::*; #(
  parameter int NUM_CS      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_STROBE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              xfer_done_i,
  input  logic              nand_rb_i,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic [BYTE_W-1:0] nand_io,
  output logic              xfer_req_o,
  output logic              xfer_wr_o,
  output logic              irq_o
);
  localparam int SMSB = SYNC_STAGES - 1;

  logic              eng_en, eng_busy, eng_done, launch, err_flag;
  logic [2:0]        imask;
  logic [REG_W-1:0]  cmd_word, addr_word;
  logic [BYTE_W-1:0] cyc0, slot_byte;
  logic [CNT_W-1:0]  strobe_t;
  logic              strobe_low, slot_cle, slot_ale, act;
  logic [CSID_W-1:0] cs;
  logic [SYNC_STAGES-1:0] rb_sync;
  logic              rb_prev, rb_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_sync <= '1;
      rb_prev <= 1'b1;
    end else begin
      rb_sync <= {rb_sync[SMSB-1:0], nand_rb_i};
      rb_prev <= rb_sync[SMSB];
    end
  end
  assign rb_rise = rb_sync[SMSB] && !rb_prev;

  nand_seq_regs #(.CNT_W(CNT_W), .DEF_STROBE(DEF_STROBE)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(eng_busy), .seq_done(eng_done),
    .rb_rise(rb_rise), .xfer_done(xfer_done_i), .en(eng_en), .launch(launch),
    .cmd_word(cmd_word), .addr_word(addr_word), .cyc0(cyc0), .strobe_t(strobe_t),
    .err_flag(err_flag), .imask(imask), .irq(irq_o)
  );

  nand_cycle_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .en(eng_en), .launch(launch), .cmd_word(cmd_word),
    .addr_word(addr_word), .cyc0(cyc0), .strobe_t(strobe_t), .busy(eng_busy),
    .done(eng_done), .strobe_low(strobe_low), .slot_cle(slot_cle), .slot_ale(slot_ale),
    .slot_byte(slot_byte), .cs(cs), .xfer_req(xfer_req_o), .xfer_wr(xfer_wr_o)
  );

  assign act = eng_busy && eng_en;

  nand_ce_decode #(.NUM_CS(NUM_CS), .CS_W(CSID_W)) u_ce (
    .clk(clk), .rst(rst), .active(act), .sel(cs), .ce_n(nand_ce_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nand_cle  <= 1'b0;
      nand_ale  <= 1'b0;
      nand_we_n <= 1'b1;
      nand_io   <= '0;
    end else begin
      nand_cle  <= act && slot_cle;
      nand_ale  <= act && slot_ale;
      nand_we_n <= !(act && strobe_low);
      nand_io   <= act ? slot_byte : '0;
    end
  end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              busy,
  input logic              err,
  input logic [2:0]        mask,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [NUM_CS-1:0] ce_n,
  input logic              cle,
  input logic              ale,
  input logic              we_n,
  input logic              irq
);
  AST_ONE_CE: assert property (@(posedge clk) disable iff (rst) $onehot0(~ce_n)); // R6
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst) !(cle && ale)); // R3
  AST_STROBE_SETUP: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |-> (cle || ale) && $stable(cle) && $stable(ale)); // R7
  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($rose(we_n) && en) |-> (cle || ale)); // R7
  AST_OFF_CE: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (&ce_n)); // R12
  AST_IDLE_WE: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> we_n); // R2
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd7 && busy) |=> err); // R8
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask == 3'b000 && $past(mask == 3'b000)) |-> !irq); // R11
endmodule

bind nand_cmd_seq nand_cmd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .en(eng_en), .busy(eng_busy), .err(err_flag), .mask(imask),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .ce_n(nand_ce_n), .cle(nand_cle),
  .ale(nand_ale), .we_n(nand_we_n), .irq(irq_o)
);

// File: tb/nand_cmd_seq_tb.sv
module nand_cmd_seq_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0, xfer_done_i = 1'b0, nand_rb_i = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  nand_ce_n, nand_io;
  logic        nand_cle, nand_ale, nand_we_n, xfer_req_o, xfer_wr_o, irq_o;

  nand_cmd_seq u_dut (.*);

  int total = 0, bad = 0;
  int cur_w = 2, lowcnt = 0, xreq_cnt = 0;
  logic prev_we = 1'b1, xreq_wr = 1'b0;

  typedef struct packed {logic cle; logic ale; logic [7:0] b; logic [7:0] ce_n; logic [7:0] w;} item_t;
  item_t exp_q[$];
  string lbl_q[$];

  task automatic check(input bit ok, input string lbl, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", lbl, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] mkcmd(input logic [7:0] c1, input logic [7:0] c2, input bit v,
                                        input int na, input int cs, input bit den, input bit dwr);
    return (32'(c1) << 2) | (32'(c2) << 10) | (32'(v) << 18) | (32'(na) << 19) |
           (32'(cs) << 22) | (32'(den) << 25) | (32'(dwr) << 26);
  endfunction

  task automatic push(input bit cle, input bit ale, input logic [7:0] b, input int cs, input string lbl);
    item_t it;
    it.cle = cle; it.ale = ale; it.b = b; it.ce_n = ~(8'd1 << cs);
    it.w = 8'((cur_w == 0) ? 1 : cur_w);
    exp_q.push_back(it); lbl_q.push_back(lbl);
  endtask

  // driver: predicts bytes from the requirements, then launches
  task automatic issue(input logic [7:0] c1, input logic [7:0] c2, input bit v, input int na,
                       input int cs, input bit den, input bit dwr, input logic [31:0] addr,
                       input logic [7:0] c0, input string lbl);
    int nn;
    nn = (na > 5) ? 5 : na;
    wr_reg(4'd6, addr);
    wr_reg(4'd5, {24'd0, c0});
    push(1, 0, c1, cs, lbl);
    for (int j = 0; j < nn; j++) begin
      if (nn == 5) push(0, 1, (j == 0) ? c0 : addr[8*(j-1) +: 8], cs, lbl);
      else         push(0, 1, addr[8*j +: 8], cs, lbl);
    end
    if (v) push(1, 0, c2, cs, lbl);
    wr_reg(4'd7, mkcmd(c1, c2, v, na, cs, den, dwr));
  endtask

  task automatic wait_idle(input string lbl);
    logic [31:0] d;
    for (int n = 0; n < 500; n++) begin
      rd_reg(4'd7, d);
      if (!d[27]) break;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, {lbl, " all predicted bytes seen"}, exp_q.size(), 0);
  endtask

  // monitor: scores each byte at the strobe's rising edge
  always @(negedge clk) begin
    if (rst) begin
      prev_we = 1'b1; lowcnt = 0;
    end else begin
      if (!nand_we_n) lowcnt++;
      if (!prev_we && nand_we_n) begin
        if (exp_q.size() == 0) begin
          check(0, "R8 R12 unexpected bus byte", {16'd0, nand_ce_n, nand_io}, 0);
        end else begin
          item_t e; string l;
          e = exp_q.pop_front(); l = lbl_q.pop_front();
          check(nand_io == e.b, {l, " byte"}, nand_io, e.b);
          check(nand_cle == e.cle && nand_ale == e.ale, {l, " R3 latch"}, {nand_cle, nand_ale}, {e.cle, e.ale});
          check(nand_ce_n == e.ce_n, {l, " R6 chip enable"}, nand_ce_n, e.ce_n);
          check(lowcnt == int'(e.w), {l, " R7 strobe width"}, lowcnt, e.w);
        end
        lowcnt = 0;
      end
      prev_we = nand_we_n;
      if (xfer_req_o) begin xreq_cnt++; xreq_wr = xfer_wr_o; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int xc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(nand_ce_n == 8'hFF && nand_we_n && !nand_cle && !nand_ale && !irq_o, "R1 idle pins",
          {nand_ce_n, nand_we_n, nand_cle, nand_ale, irq_o}, {8'hFF, 4'b1000});
    rd_reg(4'd1, d); check(d == 0, "R1 status", d, 0);
    rd_reg(4'd4, d); check(d == 0, "R1 mask", d, 0);
    rd_reg(4'd0, d); check(d == 0, "R1 engine off", d, 0);

    wr_reg(4'd0, 32'h1);
    rd_reg(4'd0, d); check(d == 1, "R12 enable readback", d, 1);

    issue(8'h70, 8'h00, 0, 0, 3, 0, 0, 32'h0, 8'h00, "R2 cmd only");
    wait_idle("R2");
    rd_reg(4'd1, d); check(d[17] == 1'b1, "R9 done bit", d, 32'h20000);
    rd_reg(4'd1, d); check(d == 0, "R9 cleared by read", d, 0);

    issue(8'h00, 8'h30, 1, 3, 0, 0, 0, 32'h00A1B2C3, 8'h00, "R4 three addr + cmd2");
    wait_idle("R4");

    issue(8'h80, 8'h10, 0, 5, 7, 0, 0, 32'h44332211, 8'h5A, "R5 five addr");
    wait_idle("R5");

    wr_reg(4'd8, 32'd4); cur_w = 4;
    issue(8'h60, 8'hD0, 1, 2, 5, 0, 0, 32'h0000BEEF, 8'h00, "R7 width4");
    wait_idle("R7");

    wr_reg(4'd8, 32'd0); cur_w = 0;
    issue(8'h90, 8'h00, 0, 7, 1, 0, 0, 32'hCAFEF00D, 8'h77, "R4 count7 width0");
    wait_idle("R4b");

    // R8 reject while busy
    wr_reg(4'd8, 32'd4); cur_w = 4;
    rd_reg(4'd1, d);
    issue(8'h85, 8'h00, 0, 5, 2, 0, 0, 32'h01020304, 8'h99, "R8 first");
    wr_reg(4'd7, mkcmd(8'hEE, 8'hEE, 1, 1, 6, 0, 0));
    rd_reg(4'd7, d); check(d[27] == 1'b1, "R8 busy bit", d, 32'h08000000);
    wait_idle("R8");
    rd_reg(4'd1, d); check(d[8] && d[17], "R8 error bit", d, 32'h20100);

    // R14 hand-off
    xc = xreq_cnt;
    issue(8'h05, 8'hE0, 1, 2, 4, 1, 1, 32'h00001234, 8'h00, "R14 data");
    wait_idle("R14");
    check(xreq_cnt == xc + 1 && xreq_wr, "R14 hand-off pulse", xreq_cnt - xc, 1);
    xc = xreq_cnt;
    issue(8'h05, 8'h00, 0, 1, 4, 0, 1, 32'h00000001, 8'h00, "R14 nodata");
    wait_idle("R14b");
    check(xreq_cnt == xc, "R14 no pulse without enable", xreq_cnt - xc, 0);

    // R10 ready/busy edges
    rd_reg(4'd1, d);
    nand_rb_i = 1'b0; repeat (6) @(negedge clk);
    rd_reg(4'd1, d); check(d[24] == 1'b0, "R10 falling ignored", d, 0);
    nand_rb_i = 1'b1; repeat (6) @(negedge clk);
    rd_reg(4'd1, d); check(d[24] == 1'b1, "R10 rising sets", d, 32'h01000000);
    @(negedge clk); xfer_done_i = 1'b1; @(negedge clk); xfer_done_i = 1'b0;
    rd_reg(4'd1, d); check(d[16] == 1'b1, "R10 data done sets", d, 32'h00010000);

    // R11 interrupt mask
    wr_reg(4'd2, 32'h0002_0000);
    rd_reg(4'd4, d); check(d == 32'h0002_0000, "R11 mask set", d, 32'h0002_0000);
    check(irq_o == 1'b0, "R11 irq low before event", irq_o, 0);
    issue(8'hFF, 8'h00, 0, 0, 0, 0, 0, 32'h0, 8'h00, "R11 seq");
    wait_idle("R11");
    check(irq_o == 1'b1, "R11 irq on done", irq_o, 1);
    rd_reg(4'd1, d); repeat (3) @(negedge clk);
    check(irq_o == 1'b0, "R11 irq drops after read", irq_o, 0);
    wr_reg(4'd3, 32'h0002_0000);
    rd_reg(4'd4, d); check(d == 0, "R11 mask cleared", d, 0);

    // R13 same-cycle event and clearing read
    @(negedge clk); reg_rd = 1'b1; reg_addr = 4'd1; xfer_done_i = 1'b1;
    @(negedge clk); reg_rd = 1'b0; xfer_done_i = 1'b0; d = reg_rdata;
    check(d[16] == 1'b0, "R13 read returns earlier value", d, 0);
    rd_reg(4'd1, d); check(d[16] == 1'b1, "R13 event survives clear", d, 32'h00010000);

    // R12 disable (both bits set: off wins), command ignored
    wr_reg(4'd0, 32'h3);
    rd_reg(4'd0, d); check(d == 0, "R12 disable wins", d, 0);
    wr_reg(4'd7, mkcmd(8'h70, 8'h00, 0, 0, 2, 0, 0));
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (nand_ce_n != 8'hFF) check(0, "R12 chip enable while off", nand_ce_n, 8'hFF);
    end
    check(nand_ce_n == 8'hFF && nand_we_n, "R12 bus quiet while off", nand_ce_n, 8'hFF);
    rd_reg(4'd7, d); check(d[27] == 1'b0, "R12 no launch while off", d, 0);
    rd_reg(4'd1, d); check(d[17] == 1'b0, "R12 no completion while off", d, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule